// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is the digital back end of a clock distribution buffer. A fast system clock carries a one-cycle enable, `tick_i`, once per time unit (tU). A phase counter advances on each tick and wraps after N ticks. N is the number of time units in one nominal output period and is picked by a three-level range select. Four output pairs are derived from the counter. Each pair has two three-level function selects that choose one of nine behaviours. Every pair can apply a signed phase offset. On the second half of the pairs, the corner codes instead give a half-rate clock, a quarter-rate clock or an inverted clock.

A three-level test select bypasses the counter. In that mode every output follows the reference input `ref_i`, and each output still applies its own divide or invert function. Function selects take effect only at the zero phase of the period, so a change made in the middle of a period never cuts a pulse short. Changing the range select restarts the counter from zero on the next tick.

Top module: `skew_clock_matrix`

## Requirements
- R1: Every three-level select is a 2-bit code: 2'b00 is LOW, 2'b01 is MID, 2'b10 is HIGH, and 2'b11 behaves exactly as MID.
- R2: The range select gives N=44 ticks for LOW, N=26 for MID and N=16 for HIGH. The counter advances by one on each cycle with `tick_i` high, wraps modulo N, and holds when `tick_i` is low. While ticks are held off, no output changes.
- R3: For pair index p, F1 is `fsel_i[4p+3:4p+2]` and F0 is `fsel_i[4p+1:4p]`. On pairs 0 and 1, the code k = 3*F1+F0 (LOW=0, MID=1, HIGH=2) selects an offset of k-4 tU, from -4 to +4. The rising edge comes offset mod N ticks after the rising edge of a 0 tU output.
- R4: On pairs 2 and 3, codes k=1..7 select an offset of 2*(k-4) tU, from -6 to +6, measured the same way.
- R5: On pairs 2 and 3, the code LOW/LOW gives a clock with period 2N and N ticks high. Its rising edges coincide with rising edges of a 0 tU output.
- R6: The code HIGH/HIGH gives, on pair 2, a clock with period 4N and 2N ticks high whose rising edges coincide with 0 tU rising edges. On pair 3 it gives the inverse of a 0 tU output: period N, rising N/2 ticks after the 0 tU rising edge, and high for N - floor(N/2) ticks.
- R7: A phase-offset output is high for floor(N/2) ticks of every N-tick period.
- R8: Both outputs of a pair are identical at all times.
- R9: A new function code takes effect only at the next counter wrap to zero. Until then, the pair keeps its previous waveform.
- R10: When the range select changes, the next tick loads the counter with zero and switches to the new period.
- R11: With the test select at MID or HIGH, offset outputs follow `ref_i` one clock later and inverted outputs give its complement. Divided outputs toggle on the rising edges of `ref_i`, in step with the following outputs.
- R12: A synchronous active-low reset clears the counter and the dividers and loads the live selects. During reset, offset outputs are high and divided outputs are low. After reset is released, the counter starts counting up from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per time unit |
| ref_i | input | 1 | Reference clock level used in test mode |
| range_sel_i | input | 2 | Three-level period select |
| test_sel_i | input | 2 | Three-level test select; LOW is normal mode |
| fsel_i | input | 16 | Function selects, four bits per pair (F1 high, F0 low) |
| q0_o | output | 4 | First output of each pair |
| q1_o | output | 4 | Second output of each pair |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a clean single-cycle enable.
- The selects are settled levels that may change at any clock edge.
- `ref_i` is a level sampled once per clock.

The bench drives all inputs just after the falling edge and toggles `ref_i` only a little after a rising edge, so every change is seen whole at the next rising edge. Ticks run every cycle except in the hold scenario. Each function code is given time to be latched at a wrap, and dividers time to settle, before any edge position is measured.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic [1:0] {
        LVL_LO  = 2'b00,
        LVL_MID = 2'b01,
        LVL_HI  = 2'b10
    } lvl_t;

    typedef enum logic [1:0] {
        FN_SHIFT = 2'b00,
        FN_DIV2  = 2'b01,
        FN_DIV4  = 2'b10,
        FN_INV   = 2'b11
    } fn_mode_t;

    typedef struct packed {
        fn_mode_t           mode;
        logic signed [4:0]  off;
    } func_t;

    // the spare code 2'b11 folds onto MID
    function automatic lvl_t lvl_of(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LO;
            2'b10:   return LVL_HI;
            default: return LVL_MID;
        endcase
    endfunction

    function automatic int lvl_num(input logic [1:0] code);
        case (lvl_of(code))
            LVL_LO:  return 0;
            LVL_HI:  return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen
    import skew_pkg::*;
#(
    parameter int N_LO  = 44,
    parameter int N_MID = 26,
    parameter int N_HI  = 16,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [1:0]       range_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] per_sel;
    logic             range_chg;

    always_comb begin
        case (lvl_of(range_i))
            LVL_LO:  per_sel = CNT_W'(N_LO);
            LVL_HI:  per_sel = CNT_W'(N_HI);
            default: per_sel = CNT_W'(N_MID);
        endcase
        range_chg = (per_sel != st_q.per);
        st_d      = st_q;
        if (tick_i) begin
            if (range_chg) begin
                st_d.cnt = '0;
                st_d.per = per_sel;
            end else if (st_q.cnt == st_q.per - 1'b1) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        wrap_o = tick_i && (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.per <= per_sel;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign per_o = st_q.per;

    assert_cnt_below_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.per);

    assert_period_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.per == CNT_W'(N_LO)) || (st_q.per == CNT_W'(N_MID)) || (st_q.per == CNT_W'(N_HI)));

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_i)) |-> ($stable(st_q.cnt) && $stable(st_q.per)));

    assert_restart_on_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_i) && $past(range_chg)) |-> (st_q.cnt == '0 && st_q.per == $past(per_sel)));

endmodule

// File: rtl/skew_func_dec.sv
module skew_func_dec
    import skew_pkg::*;
#(
    parameter bit WIDE       = 1'b0,
    parameter bit HH_QUARTER = 1'b0
) (
    input  logic [1:0] f1_i,
    input  logic [1:0] f0_i,
    output func_t      func_o
);

    int k;
    int off;

    always_comb begin
        k   = 3 * lvl_num(f1_i) + lvl_num(f0_i);
        off = WIDE ? 2 * (k - 4) : (k - 4);
        func_o.mode = FN_SHIFT;
        func_o.off  = 5'(off);
        if (WIDE && k == 0) begin
            func_o.mode = FN_DIV2;
            func_o.off  = '0;
        end else if (WIDE && k == 8) begin
            func_o.mode = HH_QUARTER ? FN_DIV4 : FN_INV;
            func_o.off  = '0;
        end
    end

endmodule

// File: rtl/skew_pair_out.sv
module skew_pair_out
    import skew_pkg::*;
#(
    parameter int PAIR_IDX  = 0,
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic             ev_i,
    input  logic             test_i,
    input  logic             ref_i,
    output logic             q0_o,
    output logic             q1_o
);

    localparam bit WIDE    = (PAIR_IDX >= NUM_PAIRS / 2);
    localparam bit QUARTER = (PAIR_IDX == NUM_PAIRS - 2);
    localparam int RW      = CNT_W + 2;

    typedef struct packed {
        func_t      fn;
        logic [1:0] div;
    } st_t;

    func_t                fn_live;
    st_t                  st_d, st_q;
    logic signed [4:0]    off_s;
    logic signed [RW-1:0] rel;
    logic signed [RW-1:0] per_s;
    logic [CNT_W-1:0]     half;
    logic                 in_win;
    logic                 out;

    skew_func_dec #(
        .WIDE       (WIDE),
        .HH_QUARTER (QUARTER)
    ) u_dec (
        .f1_i   (sel_i[3:2]),
        .f0_i   (sel_i[1:0]),
        .func_o (fn_live)
    );

    always_comb begin
        st_d = st_q;
        if (ev_i) begin
            st_d.fn  = fn_live;
            st_d.div = st_q.div + 2'd1;
        end
    end

    always_comb begin
        off_s = st_q.fn.off;
        per_s = signed'({2'b00, per_i});
        half  = per_i >> 1;
        rel   = signed'({2'b00, cnt_i}) - RW'(off_s);
        if (rel < 0) begin
            rel = rel + per_s;
        end else if (rel >= per_s) begin
            rel = rel - per_s;
        end
        in_win = rel < signed'({2'b00, half});
        case (st_q.fn.mode)
            FN_DIV2: out = st_q.div[0];
            FN_DIV4: out = st_q.div[1];
            FN_INV:  out = test_i ? ~ref_i : ~in_win;
            default: out = test_i ? ref_i : in_win;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fn  <= fn_live;
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q0_o = out;
    assign q1_o = out;

    assert_func_latched_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(st_q.fn)) |-> $past(ev_i));

    assert_divider_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(st_q.div)) |-> $past(ev_i));

    assert_div_steps_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_i)) |-> (st_q.div == $past(st_q.div) + 2'd1));

endmodule

// File: rtl/skew_clock_matrix.sv
module skew_clock_matrix
    import skew_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int N_LO      = 44,
    parameter int N_MID     = 26,
    parameter int N_HI      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   ref_i,
    input  logic [1:0]             range_sel_i,
    input  logic [1:0]             test_sel_i,
    input  logic [4*NUM_PAIRS-1:0] fsel_i,
    output logic [NUM_PAIRS-1:0]   q0_o,
    output logic [NUM_PAIRS-1:0]   q1_o
);

    localparam int N_MAX = (N_LO > N_MID) ? ((N_LO > N_HI) ? N_LO : N_HI)
                                          : ((N_MID > N_HI) ? N_MID : N_HI);
    localparam int CNT_W = $clog2(N_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per;
    logic             wrap;
    logic             test_on;
    logic             ev;
    logic             ref_d, ref_q;

    skew_phase_gen #(
        .N_LO  (N_LO),
        .N_MID (N_MID),
        .N_HI  (N_HI),
        .CNT_W (CNT_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .range_i (range_sel_i),
        .cnt_o   (cnt),
        .per_o   (per),
        .wrap_o  (wrap)
    );

    always_comb begin
        test_on = (lvl_of(test_sel_i) != LVL_LO);
        ref_d   = ref_i;
        ev      = test_on ? (ref_i && !ref_q) : wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_d;
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        skew_pair_out #(
            .PAIR_IDX  (p),
            .NUM_PAIRS (NUM_PAIRS),
            .CNT_W     (CNT_W)
        ) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (fsel_i[4*p +: 4]),
            .cnt_i  (cnt),
            .per_i  (per),
            .ev_i   (ev),
            .test_i (test_on),
            .ref_i  (ref_q),
            .q0_o   (q0_o[p]),
            .q1_o   (q1_o[p])
        );
    end

    assert_test_edge_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && ev) |=> ref_q);

endmodule

// File: tb/skew_clock_matrix_bench.sv
`timescale 1ns/1ps
module skew_clock_matrix_bench;

    localparam logic [1:0] L = 2'b00;
    localparam logic [1:0] M = 2'b01;
    localparam logic [1:0] H = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        ref_in = 1'b0;
    logic [1:0]  range_sel;
    logic [1:0]  test_sel;
    logic [15:0] fsel;
    logic [3:0]  q0, q1;

    int n_chk = 0;
    int n_bad = 0;
    bit ref_run = 1'b0;
    int ref_ph = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (ref_run) begin
            ref_ph = (ref_ph + 1) % 8;
            ref_in = (ref_ph < 4);
        end
    end

    skew_clock_matrix u_skew_clock_matrix (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .ref_i       (ref_in),
        .range_sel_i (range_sel),
        .test_sel_i  (test_sel),
        .fsel_i      (fsel),
        .q0_o        (q0),
        .q1_o        (q1)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_pair(input int p, input logic [1:0] f1, input logic [1:0] f0);
        fsel[4*p +: 4] = {f1, f0};
    endtask

    task automatic all_mm();
        for (int p = 0; p < 4; p++) set_pair(p, M, M);
    endtask

    task automatic wait_rise(input int p);
        bit prev;
        prev = q0[p];
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (q0[p] && !prev) return;
            prev = q0[p];
        end
        check(1'b0, "R2", "reference rise not seen", 0, 1);
    endtask

    task automatic measure(input int pt, input int pr, input int settle,
                           input int ex_delta, input int ex_per, input int ex_high, input string req);
        int  r1, r2, last_ref, hi, mism;
        bit  pt_prev, pr_prev;
        r1 = -1; r2 = -1; last_ref = -1; hi = 0; mism = 0;
        repeat (settle) @(negedge clk);
        pt_prev = q0[pt];
        pr_prev = q0[pr];
        for (int c = 0; c < 900 && r2 < 0; c++) begin
            @(negedge clk);
            if (q0[pt] != q1[pt] || q0[pr] != q1[pr]) mism++;
            if (r1 < 0 && q0[pr] && !pr_prev) last_ref = c;
            if (q0[pt] && !pt_prev && last_ref >= 0) begin
                if (r1 < 0) r1 = c;
                else        r2 = c;
            end
            if (r1 >= 0 && r2 < 0 && q0[pt]) hi++;
            pt_prev = q0[pt];
            pr_prev = q0[pr];
        end
        if (r2 < 0) begin
            check(1'b0, req, $sformatf("pair %0d no two rising edges", pt), r2, 0);
        end else begin
            check(r1 - last_ref == ex_delta, req, $sformatf("pair %0d rise offset", pt), r1 - last_ref, ex_delta);
            check(r2 - r1 == ex_per, req, $sformatf("pair %0d period", pt), r2 - r1, ex_per);
            check(hi == ex_high, req, $sformatf("pair %0d high ticks", pt), hi, ex_high);
        end
        check(mism == 0, "R8", $sformatf("pair %0d/%0d q0 vs q1 mismatches", pt, pr), mism, 0);
    endtask

    task automatic test_reset_R12();
        rst_n = 1'b0; tick = 1'b1; range_sel = M; test_sel = L;
        all_mm();
        set_pair(2, L, L);
        repeat (3) @(negedge clk);
        check(q0 == 4'b1011, "R12", "q0 during reset", q0, 4'b1011);
        check(q1 == 4'b1011, "R12", "q1 during reset", q1, 4'b1011);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check(q0[0] == 1'b1, "R12", "zero output high at count 12", q0[0], 1);
        @(negedge clk);
        check(q0[0] == 1'b0, "R12", "zero output low at count 13", q0[0], 0);
        repeat (12) @(negedge clk);
        check(q0[2] == 1'b0, "R12", "divider low before first wrap", q0[2], 0);
        @(negedge clk);
        check(q0[2] == 1'b1, "R12", "divider rises at first wrap", q0[2], 1);
    endtask

    task automatic sweep_all();
        logic [1:0] rc, c1, c0;
        int n, pr, k, off, ed, ep, eh;
        string req;
        for (int ri = 0; ri < 3; ri++) begin
            rc = (ri == 0) ? L : ((ri == 1) ? M : H);
            n  = (ri == 0) ? 44 : ((ri == 1) ? 26 : 16);
            range_sel = rc;
            for (int pt = 0; pt < 4; pt++) begin
                pr = (pt == 0) ? 1 : 0;
                all_mm();
                for (int a = 0; a < 3; a++) begin
                    for (int b = 0; b < 3; b++) begin
                        c1 = (a == 0) ? L : ((a == 1) ? M : H);
                        c0 = (b == 0) ? L : ((b == 1) ? M : H);
                        set_pair(pt, c1, c0);
                        k = 3 * a + b;
                        if (pt < 2) begin
                            off = k - 4;
                            ed = ((off % n) + n) % n; ep = n; eh = n / 2; req = "R3/R7";
                        end else if (k == 0) begin
                            ed = 0; ep = 2 * n; eh = n; req = "R5";
                        end else if (k == 8 && pt == 2) begin
                            ed = 0; ep = 4 * n; eh = 2 * n; req = "R6";
                        end else if (k == 8) begin
                            ed = n / 2; ep = n; eh = n - n / 2; req = "R6";
                        end else begin
                            off = 2 * (k - 4);
                            ed = ((off % n) + n) % n; ep = n; eh = n / 2; req = "R4/R7";
                        end
                        measure(pt, pr, 2 * n + 4, ed, ep, eh, req);
                    end
                end
            end
        end
    endtask

    task automatic test_spare_code_R1();
        range_sel = M;
        all_mm();
        set_pair(1, 2'b11, 2'b11);
        measure(1, 0, 60, 0, 26, 13, "R1");
        set_pair(0, 2'b11, L);
        measure(0, 1, 60, 25, 26, 13, "R1");
        all_mm();
        range_sel = 2'b11;
        measure(1, 0, 60, 0, 26, 13, "R1");
        range_sel = M;
    endtask

    task automatic test_tick_hold_R2();
        logic [3:0] s0, s1;
        int changes;
        range_sel = M;
        all_mm();
        set_pair(1, H, L);
        set_pair(2, L, H);
        set_pair(3, L, L);
        repeat (80) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        s0 = q0; s1 = q1; changes = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (q0 != s0 || q1 != s1) changes++;
        end
        check(changes == 0, "R2", "output changes with ticks held", changes, 0);
        tick = 1'b1;
        measure(1, 0, 10, 2, 26, 13, "R2");
    endtask

    task automatic test_wrap_latch_R9();
        range_sel = M;
        all_mm();
        repeat (60) @(negedge clk);
        wait_rise(1);
        repeat (2) @(negedge clk);
        set_pair(0, H, H);
        @(negedge clk);
        check(q0[0] == 1'b1, "R9", "old waveform at count 3", q0[0], 1);
        repeat (10) @(negedge clk);
        check(q0[0] == 1'b0, "R9", "old waveform at count 13", q0[0], 0);
        measure(0, 1, 60, 4, 26, 13, "R9");
    endtask

    task automatic test_range_restart_R10();
        range_sel = M;
        all_mm();
        repeat (60) @(negedge clk);
        wait_rise(0);
        repeat (20) @(negedge clk);
        check(q0[0] == 1'b0, "R10", "zero output at count 20", q0[0], 0);
        range_sel = H;
        @(negedge clk);
        check(q0[0] == 1'b1, "R10", "zero output after range change", q0[0], 1);
        measure(1, 0, 0, 0, 16, 8, "R10");
        range_sel = M;
    endtask

    task automatic follow_check(input string what);
        bit prev;
        int mism;
        mism = 0;
        @(negedge clk);
        prev = ref_in;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            if (q0[0] != prev || q0[1] != prev || q0[3] != !prev) mism++;
            prev = ref_in;
        end
        check(mism == 0, "R11", what, mism, 0);
    endtask

    task automatic test_bypass_R11();
        range_sel = M;
        set_pair(0, M, M);
        set_pair(1, H, M);
        set_pair(2, L, L);
        set_pair(3, H, H);
        test_sel = H;
        ref_run = 1'b1;
        repeat (48) @(negedge clk);
        follow_check("follow/invert mismatches, test HIGH");
        measure(2, 0, 0, 0, 16, 8, "R11");
        measure(3, 0, 0, 4, 8, 4, "R11");
        test_sel = M;
        repeat (16) @(negedge clk);
        follow_check("follow/invert mismatches, test MID");
        ref_run = 1'b0;
        test_sel = L;
        all_mm();
        repeat (60) @(negedge clk);
    endtask

    initial begin
        fsel = '0;
        test_reset_R12();
        test_spare_code_R1();
        test_tick_hold_R2();
        test_wrap_latch_R9();
        test_range_restart_R10();
        test_bypass_R11();
        sweep_all();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R2 run did not finish actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule